// File: doc/BRIEF.md
# Shared Cache Bank Arbiter

This block sits between a set of requesting cores and a shared last-level cache that is split into many banks. Each core presents one request at a time, as a valid flag and an address. The block steers the request to the bank selected by the line-address bits just above the line offset. Each bank runs its own arbiter, so requests to different banks are served in the same cycle without affecting each other.

A bank accepts a new line access at most once per busy window of `BUSY_CYC` cycles, which is modelled by a down-counter. When the bank is free, requests that were already waiting in an earlier cycle take precedence over requests that appear in the current cycle. Within the chosen group, a per-bank round-robin pointer picks the winner. This keeps the share of each bank roughly equal among colliding cores. The winner gets a one-cycle grant, and the bank raises a start strobe in the same cycle.

A core must hold its valid flag and address stable until it sees its grant. The bank count must be a power of two. The defaults are 8 cores, 16 banks, 32-bit addresses, 64-byte lines and a busy window of 8 cycles.

Top module: `llc_bank_arbiter`

## Requirements
- R1: The target bank of a request is address bits [OFF_W+BANK_W-1:OFF_W], which is bits [9:6] with the defaults. No other address bit affects which bank is chosen.
- R2: `bank_start[b]` is high in exactly those cycles in which some core whose request maps to bank b is granted. The grant and the start appear combinationally in the cycle the request is seen with the bank free. A bank with no request never starts.
- R3: After a bank starts, it does not start again for the next BUSY_CYC-1 cycles. A request that waits behind a start is started exactly BUSY_CYC cycles after it (8 with the defaults).
- R4: Banks are independent. Requests from different cores to different free banks are all granted in the same cycle.
- R5: When a bank is free and at least one of its requesters was already requesting in an earlier cycle without being granted, the grant goes to one of those waiting cores, never to a core whose request first appeared in this cycle.
- R6: Within the chosen group (waiting or new), the winner is the first requesting core found by scanning upward from the bank's pointer, wrapping after the last core. After a grant, the pointer moves to the core just after the winner.
- R7: A grant is high for one cycle per accepted request. It goes only to a core whose valid flag is high, and each bank grants at most one core per cycle.
- R8: Reset clears all busy counters, waiting flags and pointers. After reset, a request to any bank is granted in the cycle it appears, and simultaneous new requests are resolved by scanning from core 0.
- R9: When K cores keep colliding on one bank, that bank starts every BUSY_CYC cycles and each core receives one grant in every run of K grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | N_CORES | Per-core request flag, held until granted |
| req_addr | input | N_CORES*ADDR_W | Per-core request address, core c in bits [c*ADDR_W +: ADDR_W] |
| req_grant | output | N_CORES | One-cycle grant pulse per core |
| bank_start | output | N_BANKS | One-cycle access start strobe per bank |

## Verification
The embedded assertions check four properties on every cycle:
- grants and start strobes match in count;
- grants go only to requesting cores;
- each bank grants at most one core per cycle and keeps its busy spacing;
- a bank that has waiting requesters never picks a fresh arrival.

The exact choice of winner is shown only by the bench's scenarios and its behavioural queue-based model, compared on every clock. This covers the pointer position after each grant, the exact cycle in which a queued request starts, the rotation order under an eight-way collision, and the clearing of pointers and counters by a mid-run reset.

// File: rtl/llc_arb_pkg.sv
package llc_arb_pkg;

  // index after v in a ring of n entries
  function automatic int unsigned wrap_next(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // extract a w-bit field starting at bit off
  function automatic int unsigned field_at(logic [63:0] a, int unsigned off, int unsigned w);
    logic [63:0] s;
    s = a >> off;
    return int'(s[31:0] & ((32'd1 << w) - 32'd1));
  endfunction

endpackage

// File: rtl/llc_bank_map.sv
module llc_bank_map
  import llc_arb_pkg::*;
#(
  parameter int N_CORES = 8,
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 6,
  parameter int BANK_W  = 4
) (
  input  logic [N_CORES*ADDR_W-1:0] addr_i,
  output logic [N_CORES*BANK_W-1:0] bank_o
);

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    always_comb begin
      bank_o[c*BANK_W +: BANK_W] =
        BANK_W'(field_at(64'(addr_i[c*ADDR_W +: ADDR_W]), OFF_W, BANK_W));
    end
  end

endmodule

// File: rtl/llc_wait_flags.sv
module llc_wait_flags #(
  parameter int N_CORES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CORES-1:0] valid_i,
  input  logic [N_CORES-1:0] grant_i,
  output logic [N_CORES-1:0] wait_o
);

  logic [N_CORES-1:0] wait_d, wait_q;

  always_comb begin
    wait_d = valid_i & ~grant_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= '0;
    else        wait_q <= wait_d;
  end

  assign wait_o = wait_q;

endmodule

// File: rtl/llc_bank_slot.sv
module llc_bank_slot
  import llc_arb_pkg::*;
#(
  parameter int N_CORES  = 8,
  parameter int BUSY_CYC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CORES-1:0] hit_i,
  input  logic [N_CORES-1:0] wait_i,
  output logic [N_CORES-1:0] gnt_o,
  output logic               start_o
);

  localparam int PTR_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0]   busy_q, busy_d;
  logic               busy_en;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic               ptr_en;
  logic [N_CORES-1:0] cand;
  logic [PTR_W-1:0]   win;
  logic               found, free;

  // choose the waiting group when it is not empty
  always_comb begin
    cand = (|(hit_i & wait_i)) ? (hit_i & wait_i) : hit_i;
  end

  // ring scan from the pointer
  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = 0; i < N_CORES; i++) begin
      int idx;
      idx = (int'(ptr_q) + i) % N_CORES;
      if (!found && cand[idx]) begin
        found = 1'b1;
        win   = PTR_W'(idx);
      end
    end
  end

  assign free    = (busy_q == '0);
  assign start_o = free && found;

  for (genvar c = 0; c < N_CORES; c++) begin : g_gnt
    assign gnt_o[c] = start_o && (win == PTR_W'(c));
  end

  always_comb begin
    busy_en = start_o || !free;
    busy_d  = start_o ? CNT_W'(BUSY_CYC - 1) : busy_q - CNT_W'(1);
    ptr_en  = start_o;
    ptr_d   = PTR_W'(wrap_next(int'(win), N_CORES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= '0;
    else if (busy_en) busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // spacing monitor, independent of the busy counter
  logic [CNT_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gap_q <= CNT_W'(BUSY_CYC);
    else if (start_o)                  gap_q <= CNT_W'(1);
    else if (gap_q < CNT_W'(BUSY_CYC)) gap_q <= gap_q + CNT_W'(1);
  end

  // R3
  start_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (gap_q >= CNT_W'(BUSY_CYC)));

  // R7
  one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  // R5
  waiter_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && |(hit_i & wait_i)) |-> |(gnt_o & wait_i));

endmodule

// File: rtl/llc_bank_arbiter.sv
module llc_bank_arbiter #(
  parameter int N_CORES  = 8,
  parameter int N_BANKS  = 16,
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 6,
  parameter int BUSY_CYC = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CORES-1:0]        req_valid,
  input  logic [N_CORES*ADDR_W-1:0] req_addr,
  output logic [N_CORES-1:0]        req_grant,
  output logic [N_BANKS-1:0]        bank_start
);

  localparam int BANK_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1;

  logic [N_CORES*BANK_W-1:0] sel;
  logic [N_CORES-1:0]        waiting;
  logic [N_CORES-1:0]        hit  [N_BANKS];
  logic [N_CORES-1:0]        gnt_b[N_BANKS];

  llc_bank_map #(
    .N_CORES(N_CORES), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BANK_W(BANK_W)
  ) u_map (
    .addr_i(req_addr),
    .bank_o(sel)
  );

  llc_wait_flags #(.N_CORES(N_CORES)) u_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid_i(req_valid),
    .grant_i(req_grant),
    .wait_o (waiting)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    for (genvar c = 0; c < N_CORES; c++) begin : g_hit
      assign hit[b][c] = req_valid[c] && (sel[c*BANK_W +: BANK_W] == BANK_W'(b));
    end
    llc_bank_slot #(.N_CORES(N_CORES), .BUSY_CYC(BUSY_CYC)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (hit[b]),
      .wait_i (waiting),
      .gnt_o  (gnt_b[b]),
      .start_o(bank_start[b])
    );
  end

  always_comb begin
    req_grant = '0;
    for (int b = 0; b < N_BANKS; b++) req_grant = req_grant | gnt_b[b];
  end

  // R2
  grant_start_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_grant) == $countones(bank_start));

  for (genvar c = 0; c < N_CORES; c++) begin : g_chk
    // R7
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant[c] |-> req_valid[c]);
  end

endmodule

// File: tb/llc_bank_arbiter_bench.sv
`timescale 1ns/1ps
module llc_bank_arbiter_bench;

  localparam int NC = 8;
  localparam int NB = 16;
  localparam int AW = 32;
  localparam int BC = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NC-1:0]     req_valid;
  logic [NC*AW-1:0]  req_addr;
  logic [NC-1:0]     req_grant;
  logic [NB-1:0]     bank_start;

  always #4 clk = ~clk;

  llc_bank_arbiter u_llc_bank_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_grant(req_grant), .bank_start(bank_start)
  );

  int total = 0;
  int bad   = 0;

  // per-core request queues
  logic [31:0] fq [NC][16];
  int hd [NC];
  int tl [NC];

  // reference model state
  int m_busy [NB];
  int m_ptr  [NB];
  bit m_wait [NC];
  int m_win  [NB];
  bit [NC-1:0] exp_g;
  bit [NB-1:0] exp_s;
  int cyc = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int bank_of(logic [31:0] a);
    return int'((a >> 6) & 32'hF);
  endfunction

  task automatic push(int c, int bank, logic [31:0] hi);
    fq[c][tl[c] % 16] = (hi & ~32'h3C0) | (32'(bank) << 6);
    tl[c]++;
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin m_busy[b] = 0; m_ptr[b] = 0; end
    for (int c = 0; c < NC; c++) begin m_wait[c] = 0; hd[c] = 0; tl[c] = 0; end
  endtask

  task automatic eval();
    for (int c = 0; c < NC; c++) begin
      req_valid[c] = (hd[c] != tl[c]);
      req_addr[c*AW +: AW] = req_valid[c] ? fq[c][hd[c] % 16] : 32'h0;
    end
    #1;
    exp_g = '0;
    exp_s = '0;
    for (int b = 0; b < NB; b++) begin
      bit any_wait;
      bit done;
      any_wait = 0;
      done = 0;
      if (m_busy[b] == 0) begin
        for (int c = 0; c < NC; c++)
          if (req_valid[c] && bank_of(req_addr[c*AW +: AW]) == b && m_wait[c]) any_wait = 1;
        for (int i = 0; i < NC; i++) begin
          int c;
          c = (m_ptr[b] + i) % NC;
          if (!done && req_valid[c] && bank_of(req_addr[c*AW +: AW]) == b &&
              (!any_wait || m_wait[c])) begin
            done = 1; exp_g[c] = 1; exp_s[b] = 1; m_win[b] = c;
          end
        end
      end
    end
    chk(req_grant == exp_g, "R7 grant vector", longint'(req_grant), longint'(exp_g));
    chk(bank_start == exp_s, "R2 start vector", longint'(bank_start), longint'(exp_s));
  endtask

  task automatic adv();
    @(posedge clk);
    for (int b = 0; b < NB; b++) begin
      if (exp_s[b]) begin m_busy[b] = BC - 1; m_ptr[b] = (m_win[b] + 1) % NC; end
      else if (m_busy[b] > 0) m_busy[b]--;
    end
    for (int c = 0; c < NC; c++) begin
      m_wait[c] = req_valid[c] && !exp_g[c];
      if (exp_g[c]) hd[c]++;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin eval(); adv(); end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = '0;
    req_addr = '0;
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    chk(req_grant == '0, "R8 grant in reset", longint'(req_grant), 0);
    chk(bank_start == '0, "R8 start in reset", longint'(bank_start), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t_first;
    int t_second;
    int ord [24];
    int tim [24];
    int k;
    bit ok;

    do_reset();
    idle(2);

    // R1: bank from bits [9:6], other bits ignored
    push(0, 5, 32'hABCD_F03F);
    eval();
    chk(bank_start == NB'(1 << 5), "R1 bank 5 select", longint'(bank_start), 1 << 5);
    chk(req_grant == NC'(1), "R1 grant core0", longint'(req_grant), 1);
    adv();
    push(6, 15, 32'h0000_0400);
    eval();
    chk(bank_start == NB'(1 << 15), "R1 bank 15 select", longint'(bank_start), 1 << 15);
    adv();
    idle(10);

    // R4: three banks in one cycle
    push(1, 0, 32'h1111_0000);
    push(2, 1, 32'h2222_0000);
    push(3, 2, 32'h3333_0000);
    eval();
    chk(bank_start[2:0] == 3'b111, "R4 parallel starts", longint'(bank_start), 7);
    chk(req_grant == NC'(8'b0000_1110), "R4 parallel grants", longint'(req_grant), 14);
    adv();
    idle(10);

    // R3: back-to-back on bank 7
    push(0, 7, 32'h0);
    push(0, 7, 32'h8000_0000);
    t_first = -1;
    t_second = -1;
    for (int t = 0; t < 40; t++) begin
      eval();
      if (bank_start[7]) begin
        if (t_first < 0) t_first = t; else if (t_second < 0) t_second = t;
      end
      adv();
    end
    chk(t_second - t_first == BC, "R3 start spacing", t_second - t_first, BC);
    idle(4);

    // R5: waiting core 5 beats fresh core 2 although pointer favours 2
    push(0, 3, 32'h0);
    eval();
    adv();
    push(5, 3, 32'h0);
    for (int t = 0; t < 20; t++) begin
      if (m_busy[3] == 0 && hd[2] == tl[2] && hd[5] != tl[5]) push(2, 3, 32'h0);
      eval();
      if (bank_start[3]) begin
        chk(req_grant[5] && !req_grant[2], "R5 waiter beats arrival",
            longint'(req_grant), 1 << 5);
        adv();
        break;
      end
      adv();
    end
    idle(20);

    // R6 / R9: eight-way collision on bank 9
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < NC; c++) push(c, 9, 32'(c * 4096 + r));
    k = 0;
    for (int t = 0; t < 300 && k < 24; t++) begin
      eval();
      for (int c = 0; c < NC; c++)
        if (req_grant[c] && k < 24) begin ord[k] = c; tim[k] = t; k++; end
      adv();
    end
    chk(k == 24, "R9 all collision grants", k, 24);
    ok = 1;
    for (int i = 0; i < 24; i++) if (ord[i] != i % NC) ok = 0;
    chk(ok, "R6 rotation order", ok, 1);
    ok = 1;
    for (int i = 1; i < 24; i++) if (tim[i] - tim[i-1] != BC) ok = 0;
    chk(ok, "R9 even spacing", ok, 1);
    idle(4);

    // R8: mid-run reset clears pointer and busy state
    push(4, 11, 32'h0);
    eval();
    adv();
    idle(2);
    do_reset();
    push(1, 11, 32'h0);
    push(6, 11, 32'h0);
    eval();
    chk(req_grant == NC'(2), "R8 pointer cleared, busy cleared", longint'(req_grant), 2);
    adv();
    idle(20);

    // mixed random traffic against the model
    for (int t = 0; t < 2000; t++) begin
      for (int c = 0; c < NC; c++)
        if (hd[c] == tl[c] && ($urandom % 4) == 0) push(c, int'($urandom % 4), $urandom);
      eval();
      adv();
    end
    idle(80);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule